// File: doc/BRIEF.md
# CDR Manual-Lock Reset Sequencer

This block steps a serial receiver's clock-data-recovery unit from reference tracking to data tracking under manual control, and frames that change with the receiver's digital reset. A start request arms the sequence. The block then waits for calibration to finish and asks the recovery loop to lock to the reference clock. It waits until the reference-lock status has been steadily high for a glitch-filter window. It then switches the loop to data lock, keeps the digital reset applied for a settle period, releases it, and finally raises the ready flag.

Both minimum delays are counted in clock cycles derived from the `CLK_FREQ_MHZ` parameter. The qualification window is 15 us and the settle window is 4 us. Both lock-status inputs pass through two-flop synchronisers before any logic reads them. A sticky error flag records a settle window that expired while data lock was still absent. A start request is honoured only from the idle or ready state, and it runs the whole sequence again.

Top module: `cdr_lock_seq`

## Requirements
- R1: After synchronous reset, the block is idle: both lock-request outputs are low, digital reset is high, ready is low and the error flag is low.
- R2: While calibration is busy, the reference-lock request stays low and digital reset stays high. The reference-lock request rises on the cycle after the first clock edge that samples calibration as idle.
- R3: When a start is accepted with calibration idle, the reference-lock request is high one cycle later. Digital reset is high at that point and the data-lock request is low.
- R4: Ready is never high while digital reset is high.
- R5: The data-lock request rises on the clock edge that samples the raw reference-lock input high for the (15·F + 2)-th consecutive time, where F = CLK_FREQ_MHZ; two of those edges are synchroniser latency. Any single low sample restarts the count. The reference-lock request falls in the same cycle.
- R6: Once the data-lock request is high, the reference-lock input has no effect on any output.
- R7: Digital reset falls exactly 4·F cycles after the data-lock request rises. The data-lock request stays high through the ready state.
- R8: Ready rises exactly one cycle after digital reset falls.
- R9: The error flag is set when the settle window ends while the synchronised data-lock status is low. It stays set until reset or the next accepted start.
- R10: A start request is accepted only in the idle or ready state, and it is ignored during the rest of the sequence. A start accepted from ready drops the data-lock request and ready, raises digital reset, and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to run the lock sequence |
| cal_busy | input | 1 | Calibration in progress |
| ref_lock_in | input | 1 | Recovery loop locked to reference (asynchronous) |
| data_lock_in | input | 1 | Recovery loop locked to data (asynchronous) |
| req_ref_lock | output | 1 | Ask the recovery loop to lock to the reference clock |
| req_data_lock | output | 1 | Ask the recovery loop to lock to incoming data |
| rx_dig_rst | output | 1 | Receiver digital reset |
| rx_ready | output | 1 | Receiver ready for data |
| lock_err | output | 1 | Sticky: data lock missing at end of settle window |

## Verification
The hardest situation to reach from the ports is a brief reference-lock dropout landing inside the qualification window. It must restart the window without being lost in the synchroniser and without leaking into the settle phase. The stimulus raises the reference status at a random delay after the request appears, pulls it low for one cycle at a random point inside the window, and requires the data-lock request to rise on exactly the (15·F + 2)-th consecutive high edge counted after the dropout. During the settle window, the reference status is toggled randomly and the release is still required at exactly 4·F cycles. Start pulses are also injected in mid-sequence.

// File: rtl/cdr_seq_pkg.sv
package cdr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CAL   = 3'd1,
    ST_QUAL  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_REL   = 3'd4,
    ST_READY = 3'd5
  } seq_state_t;

endpackage

// File: rtl/cdr_sync2.sv
module cdr_sync2 #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/cdr_win_timer.sv
module cdr_win_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done = inc && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || done) cnt_q <= '0;
    else if (inc)           cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/cdr_lock_seq.sv
module cdr_lock_seq
  import cdr_seq_pkg::*;
#(
  parameter int CLK_FREQ_MHZ = 100,
  parameter int QUAL_US      = 15,
  parameter int SETTLE_US    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic cal_busy,
  input  logic ref_lock_in,
  input  logic data_lock_in,
  output logic req_ref_lock,
  output logic req_data_lock,
  output logic rx_dig_rst,
  output logic rx_ready,
  output logic lock_err
);

  localparam int QUAL_CYC   = QUAL_US * CLK_FREQ_MHZ;
  localparam int SETTLE_CYC = SETTLE_US * CLK_FREQ_MHZ;

  seq_state_t st_q, st_nx;
  logic [1:0] lock_s;
  logic       ref_s, data_s;
  logic       qual_clr, qual_inc, qual_done;
  logic       hold_clr, hold_inc, hold_done;
  logic       err_set, err_clr;

  cdr_sync2 #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({data_lock_in, ref_lock_in}),
    .dout (lock_s)
  );
  assign ref_s  = lock_s[0];
  assign data_s = lock_s[1];

  cdr_win_timer #(.LIMIT(QUAL_CYC)) u_qual_tmr (
    .clk (clk), .rst (rst), .clr (qual_clr), .inc (qual_inc), .done (qual_done)
  );

  cdr_win_timer #(.LIMIT(SETTLE_CYC)) u_hold_tmr (
    .clk (clk), .rst (rst), .clr (hold_clr), .inc (hold_inc), .done (hold_done)
  );

  always_comb begin
    st_nx    = st_q;
    qual_clr = 1'b1;
    qual_inc = 1'b0;
    hold_clr = 1'b1;
    hold_inc = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    case (st_q)
      ST_IDLE, ST_READY: begin
        if (start_req) begin
          st_nx   = ST_CAL;
          err_clr = 1'b1;
        end
      end
      ST_CAL: begin
        if (!cal_busy) st_nx = ST_QUAL;
      end
      ST_QUAL: begin
        qual_clr = !ref_s;
        qual_inc = ref_s;
        if (qual_done) st_nx = ST_HOLD;
      end
      ST_HOLD: begin
        hold_clr = 1'b0;
        hold_inc = 1'b1;
        if (hold_done) begin
          st_nx   = ST_REL;
          err_set = !data_s;
        end
      end
      ST_REL:  st_nx = ST_READY;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      req_ref_lock  <= 1'b0;
      req_data_lock <= 1'b0;
      rx_dig_rst    <= 1'b1;
      rx_ready      <= 1'b0;
      lock_err      <= 1'b0;
    end else begin
      st_q          <= st_nx;
      req_ref_lock  <= (st_nx == ST_QUAL);
      req_data_lock <= (st_nx == ST_HOLD) || (st_nx == ST_REL) || (st_nx == ST_READY);
      rx_dig_rst    <= !((st_nx == ST_REL) || (st_nx == ST_READY));
      rx_ready      <= (st_nx == ST_READY);
      if (err_clr)      lock_err <= 1'b0;
      else if (err_set) lock_err <= 1'b1;
    end
  end

  // R2
  ref_req_after_cal_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ref_lock) |-> $past(!cal_busy));

  // R3
  ref_req_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    req_ref_lock |-> (rx_dig_rst && !req_data_lock));

  // R4
  ready_vs_reset_chk: assert property (@(posedge clk) disable iff (rst)
    rx_dig_rst |-> !rx_ready);

  // R5
  data_req_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_data_lock) |-> $past(ref_s));

  // R7
  release_under_data_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dig_rst) |-> req_data_lock);

  // R8
  ready_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(!rx_dig_rst));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_err) |-> $past(start_req));

endmodule

// File: tb/cdr_lock_seq_tb.sv
module cdr_lock_seq_tb_top;

  localparam int F        = 2;
  localparam int QUAL_US  = 15;
  localparam int HOLD_US  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic cal_busy = 1'b0;
  logic ref_lock_in = 1'b0;
  logic data_lock_in = 1'b0;
  logic req_ref_lock, req_data_lock, rx_dig_rst, rx_ready, lock_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int run   = 0;

  always #2 clk = ~clk;

  cdr_lock_seq #(.CLK_FREQ_MHZ(F), .QUAL_US(QUAL_US), .SETTLE_US(HOLD_US)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .start_req     (start_req),
    .cal_busy      (cal_busy),
    .ref_lock_in   (ref_lock_in),
    .data_lock_in  (data_lock_in),
    .req_ref_lock  (req_ref_lock),
    .req_data_lock (req_data_lock),
    .rx_dig_rst    (rx_dig_rst),
    .rx_ready      (rx_ready),
    .lock_err      (lock_err)
  );

  function automatic int exp_qual_run();
    return QUAL_US * F + 2;
  endfunction

  function automatic int exp_hold_cycles();
    return HOLD_US * F;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    if (ref_lock_in) run++;
    else             run = 0;
    #1;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " req_ref_lock"},  req_ref_lock,  0);
    chk({tag, " req_data_lock"}, req_data_lock, 0);
    chk({tag, " rx_dig_rst"},    rx_dig_rst,    1);
    chk({tag, " rx_ready"},      rx_ready,      0);
    chk({tag, " lock_err"},      lock_err,      0);
  endtask

  // One full sequence from idle or ready.
  task automatic run_seq(input bit glitch, input bit data_ok, input bit poke);
    int n;
    data_lock_in = 1'b0;
    ref_lock_in  = 1'b0;
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    // R10: restart from any accepting state drops data request and ready
    chk("R10 restart req_data_lock low", req_data_lock, 0);
    chk("R10 restart rx_dig_rst high", rx_dig_rst, 1);
    chk("R4 ready low after restart", rx_ready, 0);
    chk("R9 error cleared by start", lock_err, 0);
    tick();
    chk("R3 req_ref_lock after start", req_ref_lock, 1);
    chk("R3 rx_dig_rst with ref request", rx_dig_rst, 1);
    chk("R3 req_data_lock low", req_data_lock, 0);
    repeat ($urandom_range(0, 4)) tick();
    ref_lock_in = 1'b1;
    if (glitch) begin
      repeat ($urandom_range(1, QUAL_US * F - 1)) tick();
      ref_lock_in = 1'b0;
      tick();
      ref_lock_in = 1'b1;
    end
    if (poke) begin
      tick();
      start_req = 1'b1;
      tick();
      start_req = 1'b0;
      chk("R10 start ignored mid-sequence", req_ref_lock, 1);
    end
    n = 0;
    while (!req_data_lock && n < 500) begin
      tick();
      n++;
    end
    chk("R5 consecutive high edges at data request", run, exp_qual_run());
    chk("R5 ref request drops with data request", req_ref_lock, 0);
    chk("R4 reset still applied", rx_dig_rst, 1);
    ref_lock_in  = 1'b0;
    data_lock_in = data_ok;
    n = 0;
    while (rx_dig_rst && n < 500) begin
      tick();
      n++;
      ref_lock_in = 1'($urandom_range(0, 1));
      if (rx_ready && rx_dig_rst) chk("R4 ready during reset", 1, 0);
    end
    chk("R7 settle cycles", n, exp_hold_cycles());
    chk("R6 ref input ignored, data request held", req_data_lock, 1);
    chk("R8 ready low at release", rx_ready, 0);
    tick();
    chk("R8 ready one cycle after release", rx_ready, 1);
    chk("R9 error flag", lock_err, data_ok ? 0 : 1);
    repeat (3) tick();
    chk("R9 error flag sticky", lock_err, data_ok ? 0 : 1);
    chk("R7 data request held in ready", req_data_lock, 1);
    chk("R6 ready unaffected by ref input", rx_ready, 1);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4321));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check_idle("R1 after reset");

    // R2: calibration busy blocks the sequence
    cal_busy = 1'b1;
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    repeat (8) tick();
    chk("R2 no ref request while cal busy", req_ref_lock, 0);
    chk("R2 reset held while cal busy", rx_dig_rst, 1);
    cal_busy = 1'b0;
    tick();
    chk("R2 ref request after cal done", req_ref_lock, 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    check_idle("R1 reset from qualification");

    // directed corners
    run_seq(1'b0, 1'b1, 1'b0);
    run_seq(1'b1, 1'b1, 1'b0);
    run_seq(1'b0, 1'b0, 1'b0);
    run_seq(1'b1, 1'b1, 1'b1);

    // random mix
    for (int i = 0; i < 10; i++) begin
      run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
              1'($urandom_range(0, 1)));
    end

    // R1: reset during the settle window
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    ref_lock_in = 1'b1;
    n = 0;
    while (!req_data_lock && n < 500) begin
      tick();
      n++;
    end
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    ref_lock_in = 1'b0;
    tick();
    check_idle("R1 reset from settle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule